// File: doc/BRIEF.md
# Center-Aligned PWM Timer

This block is a timer whose counter runs up from a programmable start value to a programmable top value and then back down to the start value, over and over. Several compare channels watch the counter. Each one drives an output pin that changes level on a compare hit, and the direction the counter is moving at that moment sets the new level. The result is a PWM waveform that is symmetric about the counter minimum. The pulse lasts twice the distance from the start value to the compare value, and the period is twice the distance from the start value to the top value.

Each channel has a two-bit mode select. One non-zero setting gives an active-high pulse, another gives the inverted pulse. Zero releases the pin, but compare hits are still recorded. Every compare hit sets a sticky per-channel event flag, and that flag raises the channel's interrupt line when enabled. A separate sticky flag marks each arrival at the top value. Writes to the top value and the compare values go into shadow registers. The running waveform picks them up only when the counter sits at the start value, so a period already in progress is never disturbed. Software reaches all of this through a simple write port and a read port with one cycle of latency.

Top module: `cpwm_timer`

## Requirements
- R1: After reset the counter equals the INIT_RST parameter and counts upward. All event flags, the overflow flag, the interrupt lines, the channel outputs and the drive enables are low, and `rd_data` is zero.
- R2: While the active top value exceeds the start value, the counter steps by one each clock. It rises to the top value, falls back to the start value and rises again, so the waveform period is 2 × (top − start) clocks.
- R3: With mode `2'b10`, a compare hit while counting down sets the channel output high on the next clock, and a hit while counting up sets it low. The high time is 2 × (compare − start) clocks.
- R4: With mode bit 0 set (`2'b01` or `2'b11`), the levels are swapped. A down-counting hit sets the output low and an up-counting hit sets it high, so the low time is 2 × (compare − start) clocks.
- R5: With mode `2'b00`, the channel's drive enable `ch_oe` and its output stay low. With any other mode, `ch_oe` is high one clock after the mode is written.
- R6: Every compare hit sets the channel event flag on the next clock, in both counting directions. `ch_irq[k]` is high exactly while flag k and its enable bit are both set.
- R7: The overflow flag `tof` is set on the clock after the counter equals the active top value.
- R8: Writing the status register clears every flag whose data bit is 1. Bits `[NUM_CH-1:0]` are the channel flags and bit `NUM_CH` is the overflow flag. A flag event in the same clock as the clear wins, and the flag stays set.
- R9: Writes to the top value and compare values land in shadow registers. They become active only on a clock where the counter is at or below the start value, so a top-value write made while counting up leaves the current period unchanged.
- R10: While the active top value is not greater than the start value, the counter holds at the start value.
- R11: Register addresses: start value at 0, top value at 1, status at 2, live count at 3 (read-only), compare of channel k at 4+2k, and control of channel k at 5+2k. The control layout is bits [1:0] mode and bit 2 interrupt enable. Reads return the addressed value on `rd_data` one clock after `rd_addr`; the top and compare addresses read back their shadow values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | CNT_W | Registered read data, one clock after `rd_addr` |
| ch_out | output | NUM_CH | Channel PWM outputs |
| ch_oe | output | NUM_CH | Channel drive enables (low when the mode is `2'b00`) |
| ch_irq | output | NUM_CH | Channel interrupt lines |
| tof | output | 1 | Sticky counter-overflow flag |

## Verification
The bench builds the timer with an 8-bit counter, three channels, a 4-bit address and a reset top value of zero. The zero top value holds the counter at the start value after reset (R10), so every register can be programmed before the waveform starts. Three channels are enough to run the true-high, inverted and released modes side by side on one counter. A short period of 12 clocks puts many periods, and several shadow-register handoffs, well inside the cycle budget.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  // register addresses; channel registers follow in pairs
  localparam int unsigned REG_START = 0;
  localparam int unsigned REG_TOP   = 1;
  localparam int unsigned REG_STAT  = 2;
  localparam int unsigned REG_COUNT = 3;
  localparam int unsigned REG_CH0   = 4;

  // channel mode values
  localparam logic [1:0] MODE_OFF = 2'b00;

  typedef struct packed {
    logic       irq_en;
    logic [1:0] mode;
  } ch_ctl_t;

  function automatic int unsigned cmp_addr(input int unsigned ch);
    return REG_CH0 + 2 * ch;
  endfunction

  function automatic int unsigned ctl_addr(input int unsigned ch);
    return REG_CH0 + 2 * ch + 1;
  endfunction

endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int NUM_CH   = 4,
  parameter int ADDR_W   = 5,
  parameter int INIT_RST = 0,
  parameter int MOD_RST  = 255
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [CNT_W-1:0]               wr_data,
  input  logic                           load,
  output logic [CNT_W-1:0]               start_q,
  output logic [CNT_W-1:0]               top_buf,
  output logic [CNT_W-1:0]               top_act,
  output logic [NUM_CH-1:0][CNT_W-1:0]   cmp_buf,
  output logic [NUM_CH-1:0][CNT_W-1:0]   cmp_act,
  output ch_ctl_t [NUM_CH-1:0]           ctl_q
);

  localparam logic [CNT_W-1:0] START_RV = CNT_W'(INIT_RST);
  localparam logic [CNT_W-1:0] TOP_RV   = CNT_W'(MOD_RST);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= START_RV;
      top_buf <= TOP_RV;
      top_act <= TOP_RV;
    end else begin
      if (wr_en && wr_addr == ADDR_W'(REG_START)) start_q <= wr_data;
      if (wr_en && wr_addr == ADDR_W'(REG_TOP))   top_buf <= wr_data;
      if (load) top_act <= top_buf;
    end
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(cmp_addr(k));
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ctl_addr(k));

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_buf[k] <= '0;
        cmp_act[k] <= '0;
        ctl_q[k]   <= '0;
      end else begin
        if (wr_en && wr_addr == A_CMP) cmp_buf[k] <= wr_data;
        if (wr_en && wr_addr == A_CTL) ctl_q[k] <= ch_ctl_t'(wr_data[2:0]);
        if (load) cmp_act[k] <= cmp_buf[k];
      end
    end
  end

endmodule

// File: rtl/cpwm_updown.sv
module cpwm_updown #(
  parameter int CNT_W    = 16,
  parameter int INIT_RST = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] start_q,
  input  logic [CNT_W-1:0] top_act,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             up_q,
  output logic             load,
  output logic             tof_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic running;
  logic ovf_set;

  assign running = top_act > start_q;
  assign load    = cnt_q <= start_q;
  assign ovf_set = running && (cnt_q == top_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_W'(INIT_RST);
      up_q  <= 1'b1;
      tof_q <= 1'b0;
    end else begin
      tof_q <= ovf_set | (tof_q & ~ovf_clr);
      if (!running) begin
        cnt_q <= start_q;
        up_q  <= 1'b1;
      end else if (up_q) begin
        if (cnt_q >= top_act) begin
          cnt_q <= cnt_q - ONE;
          up_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q + ONE;
        end
      end else begin
        if (cnt_q <= start_q) begin
          cnt_q <= cnt_q + ONE;
          up_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

endmodule

// File: rtl/cpwm_chan.sv
module cpwm_chan
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             up_q,
  input  logic [CNT_W-1:0] cmp_act,
  input  ch_ctl_t          ctl,
  input  logic             clr,
  output logic             out_q,
  output logic             oe_q,
  output logic             flag_q,
  output logic             irq
);

  logic hit;
  logic drive;

  assign hit   = cnt_q == cmp_act;
  assign drive = ctl.mode != MODE_OFF;
  assign irq   = flag_q & ctl.irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= 1'b0;
      oe_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      oe_q   <= drive;
      flag_q <= hit | (flag_q & ~clr);
      if (!drive)
        out_q <= 1'b0;
      else if (hit)
        out_q <= ctl.mode[0] ? up_q : ~up_q;
    end
  end

endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer
  import cpwm_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int NUM_CH   = 4,
  parameter int ADDR_W   = 5,
  parameter int INIT_RST = 0,
  parameter int MOD_RST  = 255
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [NUM_CH-1:0] ch_out,
  output logic [NUM_CH-1:0] ch_oe,
  output logic [NUM_CH-1:0] ch_irq,
  output logic              tof
);

  localparam int STAT_W = NUM_CH + 1;

  logic [CNT_W-1:0]             start_q;
  logic [CNT_W-1:0]             top_buf;
  logic [CNT_W-1:0]             top_act;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_buf;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_act;
  ch_ctl_t [NUM_CH-1:0]         ctl_q;
  logic [NUM_CH-1:0][1:0]       ch_mode;
  logic [CNT_W-1:0]             cnt_q;
  logic                         up_q;
  logic                         load;
  logic [NUM_CH-1:0]            ch_flag;
  logic [STAT_W-1:0]            clr_bits;
  logic [CNT_W-1:0]             rd_next;

  assign clr_bits = (wr_en && wr_addr == ADDR_W'(REG_STAT)) ? wr_data[STAT_W-1:0] : '0;

  cpwm_regs #(
    .CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W),
    .INIT_RST(INIT_RST), .MOD_RST(MOD_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(load), .start_q(start_q), .top_buf(top_buf), .top_act(top_act),
    .cmp_buf(cmp_buf), .cmp_act(cmp_act), .ctl_q(ctl_q)
  );

  cpwm_updown #(.CNT_W(CNT_W), .INIT_RST(INIT_RST)) u_cnt (
    .clk(clk), .rst(rst), .start_q(start_q), .top_act(top_act),
    .ovf_clr(clr_bits[NUM_CH]), .cnt_q(cnt_q), .up_q(up_q), .load(load), .tof_q(tof)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign ch_mode[k] = ctl_q[k].mode;
    cpwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst(rst), .cnt_q(cnt_q), .up_q(up_q), .cmp_act(cmp_act[k]),
      .ctl(ctl_q[k]), .clr(clr_bits[k]), .out_q(ch_out[k]), .oe_q(ch_oe[k]),
      .flag_q(ch_flag[k]), .irq(ch_irq[k])
    );
  end

  always_comb begin
    rd_next = '0;
    if (rd_addr == ADDR_W'(REG_START)) rd_next = start_q;
    if (rd_addr == ADDR_W'(REG_TOP))   rd_next = top_buf;
    if (rd_addr == ADDR_W'(REG_STAT))  rd_next = CNT_W'({tof, ch_flag});
    if (rd_addr == ADDR_W'(REG_COUNT)) rd_next = cnt_q;
    for (int k = 0; k < NUM_CH; k++) begin
      if (rd_addr == ADDR_W'(cmp_addr(k))) rd_next = cmp_buf[k];
      if (rd_addr == ADDR_W'(ctl_addr(k))) rd_next = CNT_W'(ctl_q[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

endmodule

// File: rtl/cpwm_timer_chk.sv
module cpwm_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic [CNT_W-1:0]             cnt_q,
  input logic                         up_q,
  input logic [CNT_W-1:0]             start_q,
  input logic [CNT_W-1:0]             top_act,
  input logic [NUM_CH-1:0][CNT_W-1:0] cmp_act,
  input logic [NUM_CH-1:0][1:0]       ch_mode,
  input logic [NUM_CH-1:0]            ch_out,
  input logic [NUM_CH-1:0]            ch_oe,
  input logic [NUM_CH-1:0]            ch_flag,
  input logic                         tof
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  p_unit_step_r2: assert property (@(posedge clk) disable iff (rst)
    (top_act > start_q && cnt_q > start_q && cnt_q < top_act)
      |=> (cnt_q == $past(cnt_q) + ONE || cnt_q == $past(cnt_q) - ONE));

  p_top_flag_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(tof) |-> $past(cnt_q == top_act));

  p_hold_start_r10: assert property (@(posedge clk) disable iff (rst)
    (top_act <= start_q) |=> (cnt_q == $past(start_q)));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    p_rise_down_r3: assert property (@(posedge clk) disable iff (rst)
      ($rose(ch_out[k]) && $past(ch_mode[k]) == 2'b10)
        |-> ($past(cnt_q) == $past(cmp_act[k]) && !$past(up_q)));

    p_rise_up_r4: assert property (@(posedge clk) disable iff (rst)
      ($rose(ch_out[k]) && $past(ch_mode[k][0]))
        |-> ($past(cnt_q) == $past(cmp_act[k]) && $past(up_q)));

    p_released_r5: assert property (@(posedge clk) disable iff (rst)
      ($past(ch_mode[k]) == 2'b00) |-> (!ch_out[k] && !ch_oe[k]));

    p_hit_flag_r6: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == cmp_act[k]) |=> ch_flag[k]);
  end

endmodule

bind cpwm_timer cpwm_timer_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .cnt_q(cnt_q), .up_q(up_q), .start_q(start_q),
  .top_act(top_act), .cmp_act(cmp_act), .ch_mode(ch_mode), .ch_out(ch_out),
  .ch_oe(ch_oe), .ch_flag(ch_flag), .tof(tof)
);

// File: tb/cpwm_timer_tb.sv
module cpwm_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 8;
  localparam int NUM_CH = 3;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [CNT_W-1:0]  wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [CNT_W-1:0]  rd_data;
  logic [NUM_CH-1:0] ch_out, ch_oe, ch_irq;
  logic              tof;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cpwm_timer #(
    .CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .INIT_RST(0), .MOD_RST(0)
  ) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ch_out(ch_out), .ch_oe(ch_oe),
    .ch_irq(ch_irq), .tof(tof)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(addr);
    wr_data = CNT_W'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic rd(input int addr, output int data);
    rd_addr = ADDR_W'(addr);
    @(negedge clk);
    data = int'(rd_data);
  endtask

  // stop at the first sample where output ch equals lvl after being !lvl
  task automatic seek(input int ch, input bit lvl);
    int g = 0;
    while (ch_out[ch] == lvl && g < 1000) begin g++; @(negedge clk); end
    while (ch_out[ch] != lvl && g < 2000) begin g++; @(negedge clk); end
  endtask

  task automatic run_len(input int ch, input bit lvl, output int n);
    n = 0;
    while (ch_out[ch] == lvl && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset;
    int v;
    check(ch_out == 0, "R1", "outputs after reset", int'(ch_out), 0);
    check(ch_oe == 0, "R1", "drive enables after reset", int'(ch_oe), 0);
    check(ch_irq == 0 && tof == 0, "R1", "irq/tof after reset", int'({tof, ch_irq}), 0);
    check(rd_data == 0, "R1", "rd_data after reset", int'(rd_data), 0);
    rd(3, v);
    check(v == 0, "R1", "count after reset", v, 0);
    rd(2, v);
    check(v == 0, "R1", "status after reset", v, 0);
  endtask

  task automatic t_setup;
    int v;
    wr(0, 2);
    wr(4, 5); wr(5, 3'b110);   // ch0: mode 10, irq on
    wr(6, 3); wr(7, 3'b001);   // ch1: mode 01
    wr(8, 6); wr(9, 3'b100);   // ch2: released, irq on
    rd(9, v);
    check(v == 4, "R11", "ctl readback ch2", v, 4);
    rd(3, v);
    check(v == 2, "R10", "held at start before top set", v, 2);
    wr(1, 8);
    rd(1, v);
    check(v == 8, "R11", "top readback", v, 8);
  endtask

  task automatic t_widths;
    int n;
    seek(0, 1); run_len(0, 1, n);
    check(n == 6, "R3", "ch0 high time", n, 6);
    run_len(0, 0, n);
    check(n == 6, "R2", "ch0 low time (period 12)", n, 6);
    seek(1, 0); run_len(1, 0, n);
    check(n == 2, "R4", "ch1 low time", n, 2);
    run_len(1, 1, n);
    check(n == 10, "R4", "ch1 high time", n, 10);
  endtask

  task automatic t_released;
    bit seen_high = 0;
    check(ch_oe == 3'b011, "R5", "drive enables", int'(ch_oe), 3);
    for (int i = 0; i < 30; i++) begin
      if (ch_out[2]) seen_high = 1;
      @(negedge clk);
    end
    check(!seen_high, "R5", "released output stays low", int'(seen_high), 0);
    check(ch_irq[2] == 1'b1, "R6", "released channel still flags", int'(ch_irq[2]), 1);
  endtask

  task automatic t_flags;
    seek(0, 1);
    wr(2, 1);
    check(ch_irq[0] == 1'b0, "R8", "ch0 flag cleared", int'(ch_irq[0]), 0);
    seek(0, 0);
    check(ch_irq[0] == 1'b1, "R6", "flag on up-count hit", int'(ch_irq[0]), 1);
    wr(2, 1);
    check(ch_irq[0] == 1'b0, "R8", "ch0 flag cleared again", int'(ch_irq[0]), 0);
    seek(0, 1);
    check(ch_irq[0] == 1'b1, "R6", "flag on down-count hit", int'(ch_irq[0]), 1);
  endtask

  task automatic t_overflow;
    seek(0, 1);
    wr(2, 1 << NUM_CH);
    check(tof == 1'b0, "R8", "overflow flag cleared", int'(tof), 0);
    seek(0, 0);
    check(tof == 1'b0, "R7", "no overflow before top", int'(tof), 0);
    seek(0, 1);
    check(tof == 1'b1, "R7", "overflow after top", int'(tof), 1);
  endtask

  task automatic t_shadow;
    int n;
    seek(0, 0);
    wr(1, 10);
    run_len(0, 0, n);
    check(n + 1 == 6, "R9", "low time with pending top write", n + 1, 6);
    run_len(0, 1, n);
    check(n == 6, "R9", "high time across handoff", n, 6);
    run_len(0, 0, n);
    check(n == 10, "R9", "low time with new top", n, 10);
  endtask

  task automatic t_hold_clear;
    int v;
    wr(1, 0);
    repeat (30) @(negedge clk);
    rd(3, v);
    check(v == 2, "R10", "count held at start", v, 2);
    wr(2, 4'b1111);
    rd(2, v);
    check(v == 0, "R8", "all flags cleared", v, 0);
    wr(8, 2);
    repeat (3) @(negedge clk);
    wr(2, 4'b0100);
    check(ch_irq[2] == 1'b1, "R8", "set wins over clear", int'(ch_irq[2]), 1);
    rd(2, v);
    check(v == 4, "R8", "status after contested clear", v, 4);
    rd(3, v);
    check(v == 2, "R10", "count still held", v, 2);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_setup();
    t_widths();
    t_released();
    t_flags();
    t_overflow();
    t_shadow();
    t_hold_clear();
    finish_run();
  end

endmodule